// File: doc/BRIEF.md
# SDRAM Command and Bank Tracker

This block sits beside the command path of an SDRAM controller and keeps track of what the memory devices must currently be doing. It samples one command per rising clock edge and decodes it. The commands are mode register set, activate, read, write, precharge and refresh. For each bank it records whether a row is open and which row that is. It holds a copy of the mode register, and it runs a timer for the burst that is currently in progress. When an access asked for auto precharge, it closes that access's bank by itself when the burst ends.

Commands arrive as a stream qualified by `cmd_valid`. The block has no ready signal and never applies back-pressure: every valid command is consumed in the cycle it is presented. A command that breaks the access rules changes no state and sets one of three sticky error flags. Only reset clears those flags. After each accepted mode register write, a hold-off window runs for a length taken from `hold_cycles`. Every command inside that window is rejected.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: After reset, every bank is idle, `mode_reg` is zero, `burst_busy` is low, and all three error flags are low.
- R2: An activate (`cmd_op` = 2) to an idle bank opens it and records `cmd_addr` as its row on the next cycle. An activate to a bank that is already open sets `err_seq` and leaves that bank's recorded row unchanged.
- R3: A read (`cmd_op` = 3) or write (`cmd_op` = 4) to an open bank, while no burst is running, raises `burst_busy` for a number of cycles set by `mode_reg[2:0]`: code 1 gives 1 cycle, code 2 gives 2, code 3 gives 4, and any other code gives 1. During that time `burst_bank`, `burst_col` (taken from `cmd_addr` low bits) and `burst_write` describe the access. An access to an idle bank, or any access while a burst is running, sets `err_seq` and starts nothing.
- R4: An access issued with `cmd_ap` = 1 closes its bank on the same clock edge at which `burst_busy` falls. Without `cmd_ap`, the bank stays open.
- R5: A precharge (`cmd_op` = 5) with `cmd_ap` = 0 closes only the bank it names. With `cmd_ap` = 1 it closes all banks. A precharge that would close the bank of a running burst sets `err_seq` and closes nothing.
- R6: A mode register set (`cmd_op` = 1) with `cmd_bank` = 0 loads `mode_reg` from `cmd_addr` on the next cycle. The field layout is bits 2:0 burst length, bit 3 burst type, bits 6:4 CAS latency, and the upper bits operating mode. A mode register set with a nonzero bank is ignored and sets no flag.
- R7: Bit 8 of `mode_reg` reads as one only in the cycle right after the write that set it, and clears itself after that.
- R8: A mode register set with `cmd_bank` = 0 while any bank is open or a burst is running sets `err_mrs` and leaves `mode_reg` unchanged.
- R9: For the `hold_cycles` cycles that follow an accepted mode register write, every valid command other than no-op (`cmd_op` = 0) sets `err_hold` and is ignored. The first command after that window is accepted normally.
- R10: A refresh (`cmd_op` = 6) while any bank is open or a burst is running sets `err_seq`. The reserved code 7 always sets `err_seq`. Neither changes bank state.
- R11: Once set, `err_seq`, `err_mrs` and `err_hold` stay high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | Command code (0 no-op, 1 mode set, 2 activate, 3 read, 4 write, 5 precharge, 6 refresh) |
| cmd_bank | input | BANK_W (2) | Bank select |
| cmd_addr | input | ROW_W (13) | Row, column or mode value |
| cmd_ap | input | 1 | Auto precharge for accesses; all-banks for precharge |
| hold_cycles | input | HOLD_W (4) | Hold-off length after a mode register write |
| bank_open | output | NUM_BANKS (4) | One bit per bank, high while a row is open |
| open_rows | output | NUM_BANKS*ROW_W (52) | Recorded row per bank, bank 0 in the low bits |
| mode_reg | output | ROW_W (13) | Current mode register |
| burst_busy | output | 1 | A burst is running |
| burst_bank | output | BANK_W (2) | Bank of the running burst |
| burst_col | output | COL_W (10) | Start column of the running burst |
| burst_write | output | 1 | Running burst is a write |
| err_seq | output | 1 | Sticky: illegal access order |
| err_mrs | output | 1 | Sticky: mode register write while not idle |
| err_hold | output | 1 | Sticky: command inside the hold-off window |

## Verification
The assertions check four rules on every cycle. The self-clearing bit never stays high for two cycles unless it is written again. Outside accepted writes, the mode register holds its value. A rejected mode write or hold-off violation raises its flag, and the error flags never fall. A burst never stays busy longer than the longest burst length. The bench scenarios are needed to show that burst length follows the mode field, that an auto-precharged bank closes on exactly the edge its burst ends, that a precharge closes the right set of banks, and that the hold-off window ends on the correct cycle.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_MRS = 3'd1,
    OP_ACT = 3'd2,
    OP_RD  = 3'd3,
    OP_WR  = 3'd4,
    OP_PRE = 3'd5,
    OP_REF = 3'd6,
    OP_BAD = 3'd7
  } trk_op_e;

  localparam int SELF_CLR_BIT = 8;

  // Clock cycles of data transfer for a burst-length code (two beats per clock).
  function automatic logic [2:0] burst_cycles(input logic [2:0] code);
    case (code)
      3'd2:    return 3'd2;
      3'd3:    return 3'd4;
      default: return 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/trk_decode.sv
module trk_decode
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input  logic                 cmd_valid,
  input  logic [2:0]           cmd_op,
  input  logic [BANK_W-1:0]    cmd_bank,
  input  logic                 cmd_ap,
  input  logic [NUM_BANKS-1:0] bank_open,
  input  logic                 burst_busy,
  input  logic [BANK_W-1:0]    burst_bank,
  input  logic                 hold_active,
  output logic                 do_mrs,
  output logic                 do_act,
  output logic                 do_acc,
  output logic [NUM_BANKS-1:0] pre_mask,
  output logic                 e_seq,
  output logic                 e_mrs,
  output logic                 e_hold
);

  trk_op_e op;
  logic    sel_open;
  logic    any_open;

  assign op       = trk_op_e'(cmd_op);
  assign sel_open = bank_open[cmd_bank];
  assign any_open = |bank_open;

  always_comb begin
    do_mrs   = 1'b0;
    do_act   = 1'b0;
    do_acc   = 1'b0;
    pre_mask = '0;
    e_seq    = 1'b0;
    e_mrs    = 1'b0;
    e_hold   = 1'b0;
    if (cmd_valid && op != OP_NOP) begin
      if (hold_active) begin
        e_hold = 1'b1;
      end else begin
        case (op)
          OP_MRS: begin
            if (cmd_bank == '0) begin
              if (any_open || burst_busy) e_mrs  = 1'b1;
              else                        do_mrs = 1'b1;
            end
          end
          OP_ACT: begin
            if (sel_open) e_seq  = 1'b1;
            else          do_act = 1'b1;
          end
          OP_RD, OP_WR: begin
            if (!sel_open || burst_busy) e_seq  = 1'b1;
            else                         do_acc = 1'b1;
          end
          OP_PRE: begin
            if (cmd_ap) begin
              if (burst_busy) e_seq    = 1'b1;
              else            pre_mask = '1;
            end else if (burst_busy && burst_bank == cmd_bank) begin
              e_seq = 1'b1;
            end else begin
              pre_mask[cmd_bank] = 1'b1;
            end
          end
          OP_REF: begin
            if (any_open || burst_busy) e_seq = 1'b1;
          end
          default: e_seq = 1'b1;
        endcase
      end
    end
  end

endmodule

// File: rtl/trk_bank.sv
module trk_bank #(
  parameter int ROW_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act,
  input  logic [ROW_W-1:0] row_in,
  input  logic             close,
  output logic             is_open,
  output logic [ROW_W-1:0] row_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open <= 1'b0;
      row_q   <= '0;
    end else if (close) begin
      is_open <= 1'b0;
    end else if (act) begin
      is_open <= 1'b1;
      row_q   <= row_in;
    end
  end

endmodule

// File: rtl/trk_burst.sv
module trk_burst #(
  parameter int COL_W  = 10,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        len_cyc,
  input  logic [BANK_W-1:0] bank_in,
  input  logic [COL_W-1:0]  col_in,
  input  logic              is_wr,
  input  logic              ap_in,
  output logic              busy,
  output logic [BANK_W-1:0] bank_q,
  output logic [COL_W-1:0]  col_q,
  output logic              wr_q,
  output logic              ap_close
);

  logic [2:0] cnt;
  logic       ap_q;

  assign busy     = (cnt != 3'd0);
  assign ap_close = (cnt == 3'd1) && ap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      ap_q   <= 1'b0;
      bank_q <= '0;
      col_q  <= '0;
      wr_q   <= 1'b0;
    end else if (start) begin
      cnt    <= len_cyc;
      ap_q   <= ap_in;
      bank_q <= bank_in;
      col_q  <= col_in;
      wr_q   <= is_wr;
    end else if (cnt != 3'd0) begin
      cnt <= cnt - 3'd1;
    end
  end

endmodule

// File: rtl/trk_mode.sv
module trk_mode
  import sdram_trk_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int HOLD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ROW_W-1:0]  wdata,
  input  logic [HOLD_W-1:0] hold_len,
  output logic [ROW_W-1:0]  mode_q,
  output logic              hold_active
);

  logic [HOLD_W-1:0] hold_cnt;

  assign hold_active = (hold_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (wr) begin
      mode_q <= wdata;
    end else begin
      mode_q[SELF_CLR_BIT] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_cnt <= '0;
    end else if (wr) begin
      hold_cnt <= hold_len;
    end else if (hold_cnt != '0) begin
      hold_cnt <= hold_cnt - 1'b1;
    end
  end

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_trk_pkg::*;
#(
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  parameter int NUM_BANKS = 4,
  parameter int HOLD_W    = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  input  logic [2:0]                 cmd_op,
  input  logic [BANK_W-1:0]          cmd_bank,
  input  logic [ROW_W-1:0]           cmd_addr,
  input  logic                       cmd_ap,
  input  logic [HOLD_W-1:0]          hold_cycles,
  output logic [NUM_BANKS-1:0]       bank_open,
  output logic [NUM_BANKS*ROW_W-1:0] open_rows,
  output logic [ROW_W-1:0]           mode_reg,
  output logic                       burst_busy,
  output logic [BANK_W-1:0]          burst_bank,
  output logic [COL_W-1:0]           burst_col,
  output logic                       burst_write,
  output logic                       err_seq,
  output logic                       err_mrs,
  output logic                       err_hold
);

  logic                 do_mrs, do_act, do_acc;
  logic [NUM_BANKS-1:0] pre_mask;
  logic                 e_seq, e_mrs, e_hold;
  logic                 hold_active;
  logic                 ap_close;

  trk_decode #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_decode (
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_bank   (cmd_bank),
    .cmd_ap     (cmd_ap),
    .bank_open  (bank_open),
    .burst_busy (burst_busy),
    .burst_bank (burst_bank),
    .hold_active(hold_active),
    .do_mrs     (do_mrs),
    .do_act     (do_act),
    .do_acc     (do_acc),
    .pre_mask   (pre_mask),
    .e_seq      (e_seq),
    .e_mrs      (e_mrs),
    .e_hold     (e_hold)
  );

  trk_mode #(.ROW_W(ROW_W), .HOLD_W(HOLD_W)) u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (do_mrs),
    .wdata      (cmd_addr),
    .hold_len   (hold_cycles),
    .mode_q     (mode_reg),
    .hold_active(hold_active)
  );

  trk_burst #(.COL_W(COL_W), .BANK_W(BANK_W)) u_burst (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (do_acc),
    .len_cyc (burst_cycles(mode_reg[2:0])),
    .bank_in (cmd_bank),
    .col_in  (cmd_addr[COL_W-1:0]),
    .is_wr   (cmd_op == OP_WR),
    .ap_in   (cmd_ap),
    .busy    (burst_busy),
    .bank_q  (burst_bank),
    .col_q   (burst_col),
    .wr_q    (burst_write),
    .ap_close(ap_close)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic close_b;
    logic act_b;
    assign close_b = pre_mask[b] || (ap_close && burst_bank == BANK_W'(b));
    assign act_b   = do_act && cmd_bank == BANK_W'(b);
    trk_bank #(.ROW_W(ROW_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .act    (act_b),
      .row_in (cmd_addr),
      .close  (close_b),
      .is_open(bank_open[b]),
      .row_q  (open_rows[b*ROW_W +: ROW_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_seq  <= 1'b0;
      err_mrs  <= 1'b0;
      err_hold <= 1'b0;
    end else begin
      err_seq  <= err_seq  | e_seq;
      err_mrs  <= err_mrs  | e_mrs;
      err_hold <= err_hold | e_hold;
    end
  end

endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
module sdram_cmd_tracker_chk
  import sdram_trk_pkg::*;
#(
  parameter int ROW_W     = 13,
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_valid,
  input logic [2:0]           cmd_op,
  input logic [BANK_W-1:0]    cmd_bank,
  input logic [NUM_BANKS-1:0] bank_open,
  input logic [ROW_W-1:0]     mode_reg,
  input logic                 burst_busy,
  input logic                 err_seq,
  input logic                 err_mrs,
  input logic                 err_hold,
  input logic                 hold_active
);

  logic mrs0;
  logic [3:0] run_len;

  assign mrs0 = cmd_valid && cmd_op == OP_MRS && cmd_bank == '0;

  always_ff @(posedge clk) begin
    if (!rst_n)          run_len <= '0;
    else if (burst_busy) run_len <= run_len + 4'd1;
    else                 run_len <= '0;
  end

  // R7
  selfclr_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_reg[SELF_CLR_BIT] && !mrs0) |=> !mode_reg[SELF_CLR_BIT]);

  // R6
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mrs0 |=> ($stable(mode_reg[7:0]) && $stable(mode_reg[ROW_W-1:9])));

  // R8
  mrs_busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mrs0 && !hold_active && (|bank_open || burst_busy)) |=> (err_mrs && $stable(mode_reg[7:0])));

  // R9
  holdoff_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op != OP_NOP && hold_active) |=> (err_hold && $stable(bank_open)));

  // R11
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_seq || err_mrs || err_hold) |=>
      ((err_seq || !$past(err_seq)) && (err_mrs || !$past(err_mrs)) && (err_hold || !$past(err_hold))));

  // R3
  burst_len_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= 4'd4);

endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(
  .ROW_W(ROW_W), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .cmd_bank   (cmd_bank),
  .bank_open  (bank_open),
  .mode_reg   (mode_reg),
  .burst_busy (burst_busy),
  .err_seq    (err_seq),
  .err_mrs    (err_mrs),
  .err_hold   (err_hold),
  .hold_active(hold_active)
);

// File: tb/test_sdram_cmd_tracker.sv
module test_sdram_cmd_tracker;

  localparam int ROW_W = 13;
  localparam int COL_W = 10;
  localparam int NB    = 4;
  localparam int BW    = 2;
  localparam int HW    = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_valid = 1'b0;
  logic [2:0]       cmd_op = '0;
  logic [BW-1:0]    cmd_bank = '0;
  logic [ROW_W-1:0] cmd_addr = '0;
  logic             cmd_ap = 1'b0;
  logic [HW-1:0]    hold_cycles = 4'd3;

  logic [NB-1:0]       bank_open;
  logic [NB*ROW_W-1:0] open_rows;
  logic [ROW_W-1:0]    mode_reg;
  logic                burst_busy;
  logic [BW-1:0]       burst_bank;
  logic [COL_W-1:0]    burst_col;
  logic                burst_write;
  logic                err_seq, err_mrs, err_hold;

  sdram_cmd_tracker i_sdram_cmd_tracker (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .cmd_ap(cmd_ap),
    .hold_cycles(hold_cycles), .bank_open(bank_open), .open_rows(open_rows),
    .mode_reg(mode_reg), .burst_busy(burst_busy), .burst_bank(burst_bank),
    .burst_col(burst_col), .burst_write(burst_write), .err_seq(err_seq),
    .err_mrs(err_mrs), .err_hold(err_hold)
  );

  always #10 clk = ~clk;

  int  checks = 0;
  int  failures = 0;
  bit  finished = 0;

  // expected state
  bit [NB-1:0]    m_open;
  bit [ROW_W-1:0] m_row [NB];
  bit [ROW_W-1:0] m_mode;
  int             m_cnt;
  bit [BW-1:0]    m_bank;
  bit [COL_W-1:0] m_col;
  bit             m_wr, m_ap;
  int             m_hold;
  bit             m_es, m_em, m_eh;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int len_for(input bit [2:0] code);
    if (code == 3'd2) return 2;
    if (code == 3'd3) return 4;
    return 1;
  endfunction

  task automatic model_reset();
    m_open = '0; m_mode = '0; m_cnt = 0; m_bank = '0; m_col = '0;
    m_wr = 0; m_ap = 0; m_hold = 0; m_es = 0; m_em = 0; m_eh = 0;
    for (int b = 0; b < NB; b++) m_row[b] = '0;
  endtask

  task automatic model_edge();
    bit dm = 0, da = 0, dacc = 0, es = 0, em = 0, eh = 0;
    bit [NB-1:0] pm = '0;
    bit apc;
    bit busy = (m_cnt != 0);
    if (cmd_valid && cmd_op != 3'd0) begin
      if (m_hold != 0) eh = 1;
      else case (cmd_op)
        3'd1: if (cmd_bank == 0) begin if (m_open != 0 || busy) em = 1; else dm = 1; end
        3'd2: if (m_open[cmd_bank]) es = 1; else da = 1;
        3'd3, 3'd4: if (!m_open[cmd_bank] || busy) es = 1; else dacc = 1;
        3'd5: if (cmd_ap) begin if (busy) es = 1; else pm = '1; end
              else if (busy && m_bank == cmd_bank) es = 1;
              else pm[cmd_bank] = 1;
        3'd6: if (m_open != 0 || busy) es = 1;
        default: es = 1;
      endcase
    end
    apc = (m_cnt == 1) && m_ap;
    for (int b = 0; b < NB; b++) begin
      if (pm[b] || (apc && m_bank == b)) m_open[b] = 0;
      else if (da && cmd_bank == b) begin m_open[b] = 1; m_row[b] = cmd_addr; end
    end
    if (dacc) begin
      m_cnt = len_for(m_mode[2:0]); m_bank = cmd_bank; m_col = cmd_addr[COL_W-1:0];
      m_wr = (cmd_op == 3'd4); m_ap = cmd_ap;
    end else if (m_cnt != 0) m_cnt--;
    if (dm) begin m_mode = cmd_addr; m_hold = hold_cycles; end
    else begin m_mode[8] = 0; if (m_hold != 0) m_hold--; end
    m_es |= es; m_em |= em; m_eh |= eh;
  endtask

  task automatic compare_all();
    chk("R2/R4/R5 bank_open", bank_open, m_open);
    for (int b = 0; b < NB; b++)
      if (m_open[b]) chk("R2 open row", open_rows[b*ROW_W +: ROW_W], m_row[b]);
    chk("R6/R7 mode_reg", mode_reg, m_mode);
    chk("R3 burst_busy", burst_busy, m_cnt != 0);
    if (m_cnt != 0) begin
      chk("R3 burst_bank", burst_bank, m_bank);
      chk("R3 burst_col", burst_col, m_col);
      chk("R3 burst_write", burst_write, m_wr);
    end
    chk("R11 err_seq", err_seq, m_es);
    chk("R8/R11 err_mrs", err_mrs, m_em);
    chk("R9/R11 err_hold", err_hold, m_eh);
  endtask

  task automatic step(input bit v, input bit [2:0] op, input bit [BW-1:0] bk,
                      input bit [ROW_W-1:0] ad, input bit ap);
    cmd_valid = v; cmd_op = op; cmd_bank = bk; cmd_addr = ad; cmd_ap = ap;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic nop();
    step(0, 3'd0, 0, 0, 0);
  endtask

  initial begin
    void'($urandom(32'd20240517));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 bank_open", bank_open, 0);
    chk("R1 mode_reg", mode_reg, 0);
    chk("R1 burst_busy", burst_busy, 0);
    chk("R1 errors", {err_seq, err_mrs, err_hold}, 0);

    // R6 / R7: write with bit 8 set, burst code 2, CAS field 3
    step(1, 3'd1, 0, 13'h132, 0);
    chk("R6 mode written", mode_reg, 13'h132);
    nop();
    chk("R7 bit8 cleared", mode_reg, 13'h032);
    nop(); nop();
    // R9 boundary: first command after 3 hold cycles is accepted
    step(1, 3'd2, 1, 13'h1A5, 0);
    chk("R9 no hold error at window end", err_hold, 0);
    chk("R2 bank1 opened", bank_open, 4'b0010);
    // R10 refresh with an open bank
    step(1, 3'd6, 0, 0, 0);
    chk("R10 refresh while open", err_seq, 1);
    // R2 activate to open bank ignored
    step(1, 3'd2, 1, 13'h0777, 0);
    chk("R2 row unchanged", open_rows[ROW_W +: ROW_W], 13'h1A5);
    // R3/R4 read with auto precharge, 2 cycles
    step(1, 3'd3, 1, 13'h02C, 1);
    chk("R3 busy start", burst_busy, 1);
    chk("R3 col", burst_col, 10'h02C);
    chk("R3 read", burst_write, 0);
    nop();
    chk("R4 bank open mid burst", bank_open[1], 1);
    nop();
    chk("R3 busy ended", burst_busy, 0);
    chk("R4 bank closed at burst end", bank_open[1], 0);
    // R3 write to idle bank ignored
    step(1, 3'd4, 2, 13'h010, 0);
    chk("R3 idle access no burst", burst_busy, 0);
    // R6 nonzero bank mode write ignored
    step(1, 3'd1, 2, 13'h005, 0);
    chk("R6 nonzero bank ignored", mode_reg, 13'h032);
    chk("R6 no mrs error", err_mrs, 0);
    // R8
    step(1, 3'd2, 0, 13'h011, 0);
    step(1, 3'd2, 3, 13'h033, 0);
    step(1, 3'd1, 0, 13'h003, 0);
    chk("R8 err_mrs", err_mrs, 1);
    chk("R8 mode unchanged", mode_reg, 13'h032);
    // R5
    step(1, 3'd5, 0, 0, 0);
    chk("R5 single precharge", bank_open, 4'b1000);
    step(1, 3'd2, 2, 13'h044, 0);
    step(1, 3'd5, 1, 0, 1);
    chk("R5 precharge all", bank_open, 4'b0000);
    // R9 violation
    hold_cycles = 4'd2;
    step(1, 3'd1, 0, 13'h033, 0);
    step(1, 3'd2, 0, 13'h055, 0);
    chk("R9 err_hold", err_hold, 1);
    chk("R9 command ignored", bank_open, 0);
    nop(); nop();
    chk("R11 flags remain", {err_seq, err_mrs, err_hold}, 3'b111);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit [2:0] op;
      bit [ROW_W-1:0] ad;
      int r = $urandom_range(0, 99);
      if (i % 500 == 0) hold_cycles = HW'($urandom_range(0, 3));
      if (r < 25)      op = 3'd2;
      else if (r < 50) op = ($urandom_range(0, 1) != 0) ? 3'd3 : 3'd4;
      else if (r < 65) op = 3'd5;
      else if (r < 72) op = 3'd1;
      else if (r < 76) op = 3'd6;
      else if (r < 78) op = 3'd7;
      else             op = 3'd0;
      ad = ROW_W'($urandom);
      if (op == 3'd1 && $urandom_range(0, 3) == 0) ad[2:0] = 3'($urandom_range(0, 7));
      step($urandom_range(0, 9) != 0, op, BW'($urandom_range(0, 3)), ad,
           $urandom_range(0, 2) == 0);
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule